// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block takes single requests from a host and carries each one out as a short series of accesses to an indirect register window. The window has an address register, a data register and a read-only version register. Every access to a target register first loads its number into the address register and then reads or writes the data register. The block supports a plain read and a plain write. It also has three read-modify-write forms (clear bits, set bits, clear-then-set), a register copy, and a poll that repeats reads until a masked value matches or a cycle budget is used up.

On some host attachments, posted writes pile up in the path and need an occasional read to drain them. When the `pci_mode` input is high, the block counts data-register writes since the last data-register read. If a write would push that run past `WRITE_RUN_MAX`, the block first reads the version register once and restarts the run at one. When `pci_mode` is low, no flush reads happen.

Top module: `indirect_reg_seq`

## Requirements
- R1: A read (`req_op`=0, also used for the unassigned code 7) writes `req_reg` to the address register (`bus_sel`=0, `bus_we`=1), then reads the data register (`bus_sel`=1, `bus_we`=0) in the next cycle. The response returns the value read.
- R2: A write (`req_op`=1) writes `req_reg` to the address register, then writes `req_value` to the data register. The response data is the value written.
- R3: Clear-bits (`req_op`=2), set-bits (3) and clear-then-set (4) read the register and write back (old & m) | s. For code 2, m=`req_mask` and s=0. For code 3, m=all ones and s=`req_value`. For code 4, m=`req_mask` and s=`req_value`. The response carries the value written.
- R4: Copy (`req_op`=5) reads `req_reg` and writes the same value to `req_dst`.
- R5: With `pci_mode`=1, each data-register write adds one to a run count. If the new count would exceed `WRITE_RUN_MAX`, one version-register read (`bus_sel`=2) comes before that write's address write, and the count becomes 1.
- R6: Every data-register read sets the run count to zero. This includes the read half of a read-modify-write, of a copy and of a poll.
- R7: With `pci_mode`=0, the version register is never read and the run count stays unchanged across writes.
- R8: Poll (`req_op`=6) reads `req_reg` repeatedly. It ends with `rsp_ok`=1 and that read's value as soon as (value & `req_mask`) == `req_value`.
- R9: After each failed poll read, the block waits `req_step` cycles and adds `req_step` to an accumulated wait. It reads again only while that wait is below `req_limit`, so it makes ceil(`req_limit`/`req_step`) reads. A timeout responds with `rsp_ok`=0 and the last value read. With `req_limit`=0 there is no bus access and the data is 0.
- R10: `req_ready` is high only while idle and no bus access is in progress. After a request is accepted, `req_ready` stays low until the response. `rsp_valid` is a single-cycle pulse. After reset, `req_ready`=1, `rsp_valid`=0 and `bus_req`=0.
- R11: A poll step of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pci_mode | input | 1 | Enables the flush read after a long write run |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 3 | Operation code |
| req_reg | input | AW | Target (or copy source) register number |
| req_dst | input | AW | Copy destination register number |
| req_mask | input | DW | Mask for clear and poll |
| req_value | input | DW | Write value, set bits or poll expected value |
| req_step | input | CW | Poll wait per retry, in cycles |
| req_limit | input | CW | Poll wait budget, in cycles |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | DW | Value read or written |
| rsp_ok | output | 1 | 1 on success, 0 on poll timeout |
| bus_req | output | 1 | Window access this cycle |
| bus_we | output | 1 | Access is a write |
| bus_sel | output | 2 | 0 address, 1 data, 2 version register |
| bus_wdata | output | DW | Write data to the window |
| bus_rdata | input | DW | Read data, valid in the same cycle as a read access |

## Verification
A table of operations is run against a single model register. Each read-modify-write step starts from a value left by the previous step, so swapped mask and set handling or a lost read becomes visible in the next readback. The write-run tests use runs of different lengths. Some runs are broken by plain reads and some by a clear-bits request, and the flush count is checked write by write; this separates an off-by-one limit, a missing restart at one and a read that fails to clear the count. Polls are tried with a first-read match, a match on a free-running register, a timeout with a step that does not divide the budget, a zero budget and a zero step. The number of reads in each case shows whether the wait accounting is correct.

// File: rtl/indirect_reg_seq.sv
module indirect_reg_seq #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 12,
  parameter int WRITE_RUN_MAX = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pci_mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_reg,
  input  logic [AW-1:0] req_dst,
  input  logic [DW-1:0] req_mask,
  input  logic [DW-1:0] req_value,
  input  logic [CW-1:0] req_step,
  input  logic [CW-1:0] req_limit,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_ok,
  output logic          bus_req,
  output logic          bus_we,
  output logic [1:0]    bus_sel,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);

  localparam int RW = $clog2(WRITE_RUN_MAX + 2);
  localparam logic [2:0] OP_READ = 3'd0, OP_WRITE = 3'd1, OP_MASK = 3'd2, OP_SET = 3'd3,
                         OP_MASKSET = 3'd4, OP_COPY = 3'd5, OP_POLL = 3'd6;
  localparam logic [1:0] SEL_ADDR = 2'd0, SEL_DATA = 2'd1, SEL_VER = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_FLUSH, S_RADDR, S_RDATA, S_WADDR, S_WDATA, S_WAIT, S_RESP} state_t;

  state_t        st;
  logic [2:0]    op;
  logic [AW-1:0] src, dst;
  logic [DW-1:0] mask, val, rdv;
  logic [CW-1:0] step, limit, dly;
  logic [CW:0]   waited;
  logic [RW-1:0] wrun;
  logic          ok;

  wire accept = req_valid && req_ready;
  wire is_poll = (op == OP_POLL);
  wire is_rmw = op inside {OP_MASK, OP_SET, OP_MASKSET, OP_COPY};
  wire match = (bus_rdata & mask) == val;
  wire [DW-1:0] wval = (rdv & mask) | val;
  wire [CW:0] waited_nx = waited + (CW+1)'(step);

  wire enter_wr = (accept && req_op == OP_WRITE) || (st == S_RDATA && is_rmw);
  wire [RW-1:0] run_base = (st == S_RDATA) ? '0 : wrun;
  wire [RW-1:0] run_inc = run_base + 1'b1;
  wire need_flush = pci_mode && (run_inc > RW'(WRITE_RUN_MAX));

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign rsp_data  = rdv;
  assign rsp_ok    = ok;

  assign bus_req = st inside {S_FLUSH, S_RADDR, S_RDATA, S_WADDR, S_WDATA};
  assign bus_we  = st inside {S_RADDR, S_WADDR, S_WDATA};

  always_comb begin
    bus_sel   = SEL_DATA;
    bus_wdata = '0;
    case (st)
      S_FLUSH: bus_sel = SEL_VER;
      S_RADDR: begin bus_sel = SEL_ADDR; bus_wdata = DW'(src); end
      S_WADDR: begin bus_sel = SEL_ADDR; bus_wdata = DW'(dst); end
      S_WDATA: bus_wdata = wval;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrun <= '0;
    end else if (enter_wr && pci_mode) begin
      wrun <= need_flush ? RW'(1) : run_inc;
    end else if (st == S_RDATA) begin
      wrun <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op <= OP_READ;
      src <= '0;
      dst <= '0;
      mask <= '0;
      val <= '0;
      rdv <= '0;
      step <= '0;
      limit <= '0;
      dly <= '0;
      waited <= '0;
      ok <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op <= (req_op == 3'd7) ? OP_READ : req_op;
          src <= req_reg;
          dst <= (req_op == OP_COPY) ? req_dst : req_reg;
          step <= (req_step == '0) ? CW'(1) : req_step;
          limit <= req_limit;
          dly <= '0;
          waited <= '0;
          rdv <= '0;
          ok <= 1'b1;
          case (req_op)
            OP_WRITE:   begin mask <= '0;       val <= req_value; end
            OP_MASK:    begin mask <= req_mask; val <= '0;        end
            OP_SET:     begin mask <= '1;       val <= req_value; end
            OP_MASKSET,
            OP_POLL:    begin mask <= req_mask; val <= req_value; end
            default:    begin mask <= '1;       val <= '0;        end
          endcase
          if (req_op == OP_WRITE) begin
            st <= need_flush ? S_FLUSH : S_WADDR;
          end else if (req_op == OP_POLL && req_limit == '0) begin
            ok <= 1'b0;
            st <= S_RESP;
          end else begin
            st <= S_RADDR;
          end
        end
        S_FLUSH: st <= S_WADDR;
        S_RADDR: st <= S_RDATA;
        S_RDATA: begin
          rdv <= bus_rdata;
          if (is_poll) st <= match ? S_RESP : S_WAIT;
          else if (is_rmw) st <= need_flush ? S_FLUSH : S_WADDR;
          else st <= S_RESP;
        end
        S_WAIT: begin
          if (dly == step - 1'b1) begin
            dly <= '0;
            waited <= waited_nx;
            if (waited_nx < (CW+1)'(limit)) begin
              st <= S_RADDR;
            end else begin
              ok <= 1'b0;
              st <= S_RESP;
            end
          end else begin
            dly <= dly + 1'b1;
          end
        end
        S_WADDR: st <= S_WDATA;
        S_WDATA: begin
          rdv <= wval;
          st <= S_RESP;
        end
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/indirect_reg_seq_chk.sv
module indirect_reg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pci_mode,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       bus_req,
  input logic       bus_we,
  input logic [1:0] bus_sel
);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req);

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_data_after_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_sel == 2'd1) |-> $past(bus_req && bus_we && bus_sel == 2'd0));

  p_flush_then_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_sel == 2'd2) |=> (bus_req && bus_we && bus_sel == 2'd0));

  p_no_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_sel == 2'd2) |-> $past(pci_mode));

  p_ver_readonly_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_sel == 2'd2) |-> !bus_we);

endmodule

bind indirect_reg_seq indirect_reg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pci_mode(pci_mode), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .bus_req(bus_req),
  .bus_we(bus_we), .bus_sel(bus_sel)
);

// File: tb/indirect_reg_seq_tb_top.sv
`timescale 1ns/1ps
module indirect_reg_seq_tb_top;
  localparam int MAXRUN = 4;

  logic clk = 1'b0, rst_n = 1'b0, pci_mode = 1'b0, req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_reg = '0, req_dst = '0;
  logic [15:0] req_mask = '0, req_value = '0;
  logic [11:0] req_step = '0, req_limit = '0;
  logic req_ready, rsp_valid, rsp_ok, bus_req, bus_we;
  logic [15:0] rsp_data, bus_wdata, bus_rdata;
  logic [1:0] bus_sel;

  always #2 clk = ~clk;

  indirect_reg_seq #(.AW(8), .DW(16), .CW(12), .WRITE_RUN_MAX(MAXRUN)) dut_i (
    .clk(clk), .rst_n(rst_n), .pci_mode(pci_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_reg(req_reg), .req_dst(req_dst),
    .req_mask(req_mask), .req_value(req_value), .req_step(req_step),
    .req_limit(req_limit), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_ok(rsp_ok), .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  logic [7:0] addr_q;
  logic [15:0] mem [256];
  logic [15:0] cyc;
  int ver_reads, data_reads;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= {i[7:0], ~i[7:0]};
      addr_q <= '0;
      cyc <= '0;
      ver_reads <= 0;
      data_reads <= 0;
    end else begin
      cyc <= cyc + 1'b1;
      if (bus_req) begin
        if (bus_we && bus_sel == 2'd0) addr_q <= bus_wdata[7:0];
        else if (bus_we && bus_sel == 2'd1) mem[addr_q] <= bus_wdata;
        else if (!bus_we && bus_sel == 2'd1) data_reads <= data_reads + 1;
        else if (!bus_we && bus_sel == 2'd2) ver_reads <= ver_reads + 1;
      end
    end
  end

  assign bus_rdata = (bus_sel == 2'd2) ? 16'hBEEF :
                     (addr_q == 8'hF0) ? cyc : mem[addr_q];

  int n_checks = 0, n_fail = 0;

  task automatic check(input logic cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] rg, input logic [7:0] ds,
                       input logic [15:0] m, input logic [15:0] v, input logic [11:0] st,
                       input logic [11:0] lim, output logic [15:0] d, output logic okv);
    int n;
    @(negedge clk);
    req_op = op; req_reg = rg; req_dst = ds; req_mask = m; req_value = v;
    req_step = st; req_limit = lim; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready || rsp_valid, "R10 ready low while busy", {31'd0, req_ready}, 32'd0);
    n = 0;
    while (!rsp_valid && n < 3000) begin @(negedge clk); n++; end
    check(rsp_valid, "R10 response arrives", {31'd0, rsp_valid}, 32'd1);
    check(!req_ready, "R10 not ready during response", {31'd0, req_ready}, 32'd0);
    d = rsp_data; okv = rsp_ok;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R10 single-cycle response", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  localparam int NV = 10;
  localparam logic [66:0] VEC [NV] = '{
    {3'd0, 8'h10, 8'h00, 16'h0000, 16'h0000, 16'h10EF},
    {3'd1, 8'h10, 8'h00, 16'h0000, 16'h1234, 16'h1234},
    {3'd0, 8'h10, 8'h00, 16'h0000, 16'h0000, 16'h1234},
    {3'd2, 8'h10, 8'h00, 16'hFF00, 16'h0000, 16'h1200},
    {3'd3, 8'h10, 8'h00, 16'h0000, 16'h0081, 16'h1281},
    {3'd4, 8'h10, 8'h00, 16'h0F0F, 16'hA050, 16'hA251},
    {3'd0, 8'h10, 8'h00, 16'h0000, 16'h0000, 16'hA251},
    {3'd5, 8'h10, 8'h20, 16'h0000, 16'h0000, 16'hA251},
    {3'd0, 8'h20, 8'h00, 16'h0000, 16'h0000, 16'hA251},
    {3'd7, 8'h21, 8'h00, 16'h0000, 16'h0000, 16'h21DE}
  };

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd1: return "R2 write";
      3'd2, 3'd3, 3'd4: return "R3 mask/set";
      3'd5: return "R4 copy";
      default: return "R1 read";
    endcase
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic okv;
    int v0, r0;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !bus_req, "R10 reset state",
          {29'd0, req_ready, rsp_valid, bus_req}, 32'd4);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][66:64], VEC[i][63:56], VEC[i][55:48], VEC[i][47:32], VEC[i][31:16], 12'd0, 12'd0, d, okv);
      check(d == VEC[i][15:0] && okv, tag_of(VEC[i][66:64]), {15'd0, okv, d}, {16'd1, VEC[i][15:0]});
    end

    // R8 first-read match
    r0 = data_reads;
    issue(3'd6, 8'h10, 8'h00, 16'hFF00, 16'hA200, 12'd3, 12'd50, d, okv);
    check(okv && d == 16'hA251 && data_reads - r0 == 1, "R8 poll immediate match",
          {okv, 15'(data_reads - r0), d}, {1'b1, 15'd1, 16'hA251});
    // R8 match on a changing register
    issue(3'd6, 8'hF0, 8'h00, 16'h000F, 16'h0007, 12'd3, 12'd400, d, okv);
    check(okv && d[3:0] == 4'h7, "R8 poll later match", {15'd0, okv, d}, {16'd1, 16'h0007});
    // R9 timeout, ceil(10/3)=4 reads
    r0 = data_reads;
    issue(3'd6, 8'h10, 8'h00, 16'hFFFF, 16'h0000, 12'd3, 12'd10, d, okv);
    check(!okv && d == 16'hA251 && data_reads - r0 == 4, "R9 poll timeout",
          {okv, 15'(data_reads - r0), d}, {1'b0, 15'd4, 16'hA251});
    // R9 zero budget
    r0 = data_reads;
    issue(3'd6, 8'h10, 8'h00, 16'hFFFF, 16'h0000, 12'd3, 12'd0, d, okv);
    check(!okv && d == 16'h0000 && data_reads == r0, "R9 poll zero budget",
          {okv, 15'(data_reads - r0), d}, 32'd0);
    // R11 step zero acts as one
    r0 = data_reads;
    issue(3'd6, 8'h10, 8'h00, 16'hFFFF, 16'h0000, 12'd0, 12'd3, d, okv);
    check(!okv && data_reads - r0 == 3, "R11 zero step", {okv, 31'(data_reads - r0)}, 32'd3);

    // R7 no flush when mode off
    v0 = ver_reads;
    for (int k = 0; k < 12; k++) issue(3'd1, 8'h30, 8'h00, 16'h0, 16'(k), 12'd0, 12'd0, d, okv);
    check(ver_reads == v0, "R7 no flush in plain mode", 32'(ver_reads - v0), 32'd0);
    issue(3'd0, 8'h30, 8'h00, 16'h0, 16'h0, 12'd0, 12'd0, d, okv);
    check(d == 16'd11, "R7 writes landed", {16'd0, d}, 32'd11);

    // R5 flush on 5th and 9th write
    pci_mode = 1'b1;
    issue(3'd0, 8'h30, 8'h00, 16'h0, 16'h0, 12'd0, 12'd0, d, okv);
    for (int k = 1; k <= 9; k++) begin
      v0 = ver_reads;
      issue(3'd1, 8'h30, 8'h00, 16'h0, 16'(k), 12'd0, 12'd0, d, okv);
      check(ver_reads - v0 == ((k == 5 || k == 9) ? 1 : 0), $sformatf("R5 flush write %0d", k),
            32'(ver_reads - v0), (k == 5 || k == 9) ? 32'd1 : 32'd0);
    end
    issue(3'd0, 8'h30, 8'h00, 16'h0, 16'h0, 12'd0, 12'd0, d, okv);
    check(d == 16'd9, "R5 flushed write landed", {16'd0, d}, 32'd9);

    // R6 read clears run
    v0 = ver_reads;
    for (int k = 0; k < 3; k++) issue(3'd1, 8'h30, 8'h00, 16'h0, 16'h5, 12'd0, 12'd0, d, okv);
    issue(3'd0, 8'h30, 8'h00, 16'h0, 16'h0, 12'd0, 12'd0, d, okv);
    for (int k = 0; k < 4; k++) issue(3'd1, 8'h30, 8'h00, 16'h0, 16'h6, 12'd0, 12'd0, d, okv);
    check(ver_reads == v0, "R6 read resets run", 32'(ver_reads - v0), 32'd0);
    issue(3'd1, 8'h30, 8'h00, 16'h0, 16'h7, 12'd0, 12'd0, d, okv);
    check(ver_reads - v0 == 1, "R6 flush after fresh run", 32'(ver_reads - v0), 32'd1);

    // R6 read half of a mask request clears run
    issue(3'd0, 8'h30, 8'h00, 16'h0, 16'h0, 12'd0, 12'd0, d, okv);
    v0 = ver_reads;
    for (int k = 0; k < 4; k++) issue(3'd1, 8'h30, 8'h00, 16'h0, 16'h00F0, 12'd0, 12'd0, d, okv);
    issue(3'd2, 8'h30, 8'h00, 16'h0030, 16'h0, 12'd0, 12'd0, d, okv);
    check(ver_reads == v0 && d == 16'h0030, "R6 mask read resets run",
          {16'(ver_reads - v0), d}, {16'd0, 16'h0030});
    for (int k = 0; k < 3; k++) issue(3'd1, 8'h30, 8'h00, 16'h0, 16'h1, 12'd0, 12'd0, d, okv);
    check(ver_reads == v0, "R6 no flush within run", 32'(ver_reads - v0), 32'd0);
    issue(3'd1, 8'h30, 8'h00, 16'h0, 16'h2, 12'd0, 12'd0, d, okv);
    check(ver_reads - v0 == 1, "R5 flush counts mask write", 32'(ver_reads - v0), 32'd1);

    finish_run();
  end
endmodule